// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block is a small fully associative translation buffer. It turns a virtual address into a physical address by comparing the virtual page number against every stored entry at once. Each entry records its own page size, so one buffer can hold 8 KB, 64 KB, 256 KB and 4 MB mappings side by side. For each entry, the page-number bits that fall inside that entry's page are left out of the compare and copied straight from the virtual address.

A requester raises `req_valid` with an address and holds both until `req_ready` is high. A hit completes in the same cycle. On a miss the block stalls the requester and asks a page-table port for the mapping. It writes the returned mapping into a victim entry and then repeats the lookup, which now hits. The port can answer with a fault instead. In that case nothing is stored and the requester gets a fault indication.

An invalidate-all input empties the buffer in one cycle. The entry count and the address widths are parameters.

Top module: `mpsz_tlb`

## Requirements
- R1: The low 13 bits of the virtual address are the byte offset. They appear unchanged as the low 13 bits of `rsp_pa` for every page size. The bits above them are the entry's physical page number.
- R2: The 2-bit page-size field selects how many low page-number bits an entry passes through: 00 = 8 KB passes 0, 01 = 64 KB passes 3, 10 = 256 KB passes 5, 11 = 4 MB passes 9. Passed bits are excluded from the tag compare. In the physical page number they are taken from the virtual address, and the remaining bits come from the entry's stored base.
- R3: When a valid entry matches, `req_ready` is high in the same cycle as the request, with the translated address, and no walk is issued.
- R4: When no valid entry matches, `req_ready` stays low. In the next cycle `walk_req` rises and presents the request's virtual page number on `walk_vpn`, and holds it until `walk_rsp_valid`. After a non-fault response the mapping is stored and the lookup completes one cycle later, so a miss takes two cycles from request to `req_ready`.
- R5: A refill goes to the lowest-numbered invalid entry when one exists.
- R6: When every entry is valid, a refill evicts entries in round-robin order starting from entry 0. The evicted translation is lost and its next lookup walks again.
- R7: If several valid entries match, the lowest-numbered one supplies the address and `rsp_multi` is high for that lookup. Otherwise `rsp_multi` is low.
- R8: A response with `walk_rsp_fault` high stores nothing. In the next cycle `req_ready` and `rsp_fault` are both high. Existing entries are unchanged, and a repeat of the address walks again.
- R9: A cycle with `flush` high invalidates every entry and returns the round-robin pointer to entry 0.
- R10: After reset the buffer holds no valid entry, `walk_req` and `rsp_fault` are low, and the first lookup walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_va | input | VA_W | Virtual address, held until ready |
| req_ready | output | 1 | Request completes this cycle |
| rsp_pa | output | PA_W | Physical address (no fault) |
| rsp_fault | output | 1 | Translation fault for this request |
| rsp_multi | output | 1 | More than one entry matched |
| walk_req | output | 1 | Page-table fetch request |
| walk_vpn | output | VA_W-13 | Virtual page number to fetch |
| walk_rsp_valid | input | 1 | Page-table response present |
| walk_rsp_fault | input | 1 | No mapping exists |
| walk_rsp_size | input | 2 | Page-size code of the mapping |
| walk_rsp_pbase | input | PA_W-13 | Physical page number base |

## Verification
Each page size is tried at the offsets inside its page. A sweep over every 8 KB sub-page of a 64 KB page and samples across a 4 MB page show that the pass-through bits come from the virtual address. Addresses just past each page are answered with faults, which shows that the masked compare does not reach beyond the page, while the buffer contents stay untouched. A full buffer is then refilled twice before and after an invalidate. Which old translations still hit tells apart round-robin order, a pointer reset and the lowest-invalid preference. A small page nested inside a 4 MB page produces a double match, which tells lowest-index selection apart from any other choice.

// File: rtl/mpsz_tlb_pkg.sv
package mpsz_tlb_pkg;
  localparam int OFF_W = 13;

  typedef enum logic [1:0] {
    ST_LOOK  = 2'b00,
    ST_WALK  = 2'b01,
    ST_FAULT = 2'b10
  } ctl_state_e;

  // page-size code -> low page-number bits passed through
  function automatic int pass_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 0;
      2'b01:   return 3;
      2'b10:   return 5;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/mpsz_tlb_cmp.sv
module mpsz_tlb_cmp import mpsz_tlb_pkg::*; #(
  parameter int VPN_W = 19,
  parameter int PPN_W = 19
) (
  input  logic             valid,
  input  logic [1:0]       size,
  input  logic [VPN_W-1:0] tag,
  input  logic [PPN_W-1:0] base,
  input  logic [VPN_W-1:0] vpn,
  output logic             match,
  output logic [PPN_W-1:0] pn
);
  int               extra;
  logic [VPN_W-1:0] vmask;
  logic [PPN_W-1:0] pmask;
  logic [PPN_W-1:0] vlow;

  always_comb begin
    extra = pass_bits(size);
    for (int i = 0; i < VPN_W; i++) vmask[i] = (i < extra);
    for (int i = 0; i < PPN_W; i++) pmask[i] = (i < extra);
  end

  assign vlow  = PPN_W'(vpn);
  assign match = valid && (((tag ^ vpn) & ~vmask) == '0);
  assign pn    = (base & ~pmask) | (vlow & pmask);
endmodule

// File: rtl/mpsz_tlb_victim.sv
module mpsz_tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [ENTRIES-1:0] valid,
  input  logic               install,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] rr_q;
  logic             all_valid;

  assign all_valid = &valid;

  always_comb begin
    victim = rr_q;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) victim = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst || flush)
      rr_q <= '0;
    else if (install && all_valid)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  // R5
  victim_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (install && !all_valid) |-> !valid[victim]);
endmodule

// File: rtl/mpsz_tlb_ctrl.sv
module mpsz_tlb_ctrl import mpsz_tlb_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic any_hit,
  input  logic walk_rsp_valid,
  input  logic walk_rsp_fault,
  output logic req_ready,
  output logic in_fault,
  output logic walk_req,
  output logic install
);
  ctl_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_LOOK;
    else begin
      case (st_q)
        ST_LOOK:  if (req_valid && !any_hit) st_q <= ST_WALK;
        ST_WALK:  if (walk_rsp_valid) st_q <= walk_rsp_fault ? ST_FAULT : ST_LOOK;
        ST_FAULT: if (req_valid) st_q <= ST_LOOK;
        default:  st_q <= ST_LOOK;
      endcase
    end
  end

  assign walk_req  = (st_q == ST_WALK);
  assign in_fault  = (st_q == ST_FAULT);
  assign req_ready = ((st_q == ST_LOOK) && any_hit) || in_fault;
  assign install   = walk_req && walk_rsp_valid && !walk_rsp_fault;

  // R4
  walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !walk_rsp_valid) |=> walk_req);

  // R8
  fault_report_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && walk_rsp_valid && walk_rsp_fault) |=> (req_ready && in_fault));
endmodule

// File: rtl/mpsz_tlb.sv
module mpsz_tlb import mpsz_tlb_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_va,
  output logic                  req_ready,
  output logic [PA_W-1:0]       rsp_pa,
  output logic                  rsp_fault,
  output logic                  rsp_multi,
  output logic                  walk_req,
  output logic [VA_W-OFF_W-1:0] walk_vpn,
  input  logic                  walk_rsp_valid,
  input  logic                  walk_rsp_fault,
  input  logic [1:0]            walk_rsp_size,
  input  logic [PA_W-OFF_W-1:0] walk_rsp_pbase
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   base_q [ENTRIES];
  logic [1:0]         size_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  logic [ENTRIES-1:0] hit_vec;
  logic [PPN_W-1:0]   pn_arr [ENTRIES];
  logic [VPN_W-1:0]   lk_vpn;
  logic [IDX_W-1:0]   sel, victim;
  logic               any_hit, multi, install;

  assign lk_vpn   = req_va[VA_W-1:OFF_W];
  assign walk_vpn = lk_vpn;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    mpsz_tlb_cmp #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_cmp (
      .valid (valid_q[g]),
      .size  (size_q[g]),
      .tag   (tag_q[g]),
      .base  (base_q[g]),
      .vpn   (lk_vpn),
      .match (hit_vec[g]),
      .pn    (pn_arr[g])
    );
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) sel = IDX_W'(i);
  end

  assign any_hit = |hit_vec;
  assign multi   = ($countones(hit_vec) > 1);
  assign rsp_pa  = {pn_arr[sel], req_va[OFF_W-1:0]};
  assign rsp_multi = multi && req_ready && !rsp_fault;

  mpsz_tlb_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .any_hit        (any_hit),
    .walk_rsp_valid (walk_rsp_valid),
    .walk_rsp_fault (walk_rsp_fault),
    .req_ready      (req_ready),
    .in_fault       (rsp_fault),
    .walk_req       (walk_req),
    .install        (install)
  );

  mpsz_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .valid   (valid_q),
    .install (install),
    .victim  (victim)
  );

  // entry payload: write-only-on-refill array
  always_ff @(posedge clk) begin
    if (install) begin
      tag_q[victim]  <= lk_vpn;
      base_q[victim] <= walk_rsp_pbase;
      size_q[victim] <= walk_rsp_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (install) valid_q[victim] <= 1'b1;
  end

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !any_hit);

  // R4
  install_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (install && !flush) |=> valid_q[$past(victim)]);

  // R8
  fault_nostore_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && walk_rsp_valid && walk_rsp_fault && !flush) |=> $stable(valid_q));

  // R7
  multi_sel_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> (hit_vec[sel] && $countones(hit_vec) >= 2));
endmodule

// File: tb/mpsz_tlb_bench.sv
module mpsz_tlb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, rsp_fault, rsp_multi, walk_req;
  logic [31:0] rsp_pa;
  logic [18:0] walk_vpn;
  logic        walk_rsp_valid = 1'b0;
  logic        walk_rsp_fault = 1'b0;
  logic [1:0]  walk_rsp_size = '0;
  logic [18:0] walk_rsp_pbase = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  mpsz_tlb #(.ENTRIES(4), .VA_W(32), .PA_W(32)) u_mpsz_tlb (
    .clk, .rst, .flush, .req_valid, .req_va, .req_ready, .rsp_pa,
    .rsp_fault, .rsp_multi, .walk_req, .walk_vpn, .walk_rsp_valid,
    .walk_rsp_fault, .walk_rsp_size, .walk_rsp_pbase
  );

  task automatic check(input string tag, input bit ok,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xpa(input logic [31:0] va, input logic [1:0] sz,
                                      input logic [18:0] pb);
    int k;
    logic [18:0] m;
    k = (sz == 2'd0) ? 0 : (sz == 2'd1) ? 3 : (sz == 2'd2) ? 5 : 9;
    m = 19'((32'd1 << k) - 1);
    return {(pb & ~m) | (va[31:13] & m), va[12:0]};
  endfunction

  // one request; the bench acts as page-table walker
  task automatic xlate(input string tag, input logic [31:0] va, input logic [1:0] sz,
                       input logic [18:0] pb, input bit flt, input bit exp_walk,
                       input logic [31:0] epa, input bit exp_multi);
    int n = 0;
    bit walked = 0;
    req_valid = 1'b1;
    req_va    = va;
    #1;
    while (!req_ready && n < 20) begin
      if (walk_req) begin
        walked = 1;
        check({"R4 walk_vpn ", tag}, walk_vpn == va[31:13], 32'(walk_vpn), 32'(va[31:13]));
        walk_rsp_valid = 1'b1; walk_rsp_fault = flt;
        walk_rsp_size  = sz;   walk_rsp_pbase = pb;
      end
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      #1;
      n++;
    end
    check({"ready ", tag}, req_ready, 32'(req_ready), 32'd1);
    check({"walk ", tag}, walked == exp_walk, 32'(walked), 32'(exp_walk));
    check({exp_walk ? "R4 latency " : "R3 latency ", tag}, n == (exp_walk ? 2 : 0),
          32'(n), exp_walk ? 32'd2 : 32'd0);
    check({"R8 fault flag ", tag}, rsp_fault == flt, 32'(rsp_fault), 32'(flt));
    if (!flt) begin
      check({"R1 pa ", tag}, rsp_pa == epa, rsp_pa, epa);
      check({"R7 multi ", tag}, rsp_multi == exp_multi, 32'(rsp_multi), 32'(exp_multi));
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // hit lookup of a page already installed
  task automatic hit(input string tag, input logic [31:0] va, input logic [1:0] sz,
                     input logic [18:0] pb);
    xlate(tag, va, sz, pb, 1'b0, 1'b0, xpa(va, sz, pb), 1'b0);
  endtask

  // miss with a good refill
  task automatic fill(input string tag, input logic [31:0] va, input logic [1:0] sz,
                      input logic [18:0] pb);
    xlate(tag, va, sz, pb, 1'b0, 1'b1, xpa(va, sz, pb), 1'b0);
  endtask

  // miss answered by a fault
  task automatic probe(input string tag, input logic [31:0] va);
    xlate(tag, va, 2'd0, 19'd0, 1'b1, 1'b1, 32'd0, 1'b0);
  endtask

  localparam logic [31:0] VA_A = 32'h0000_2ABC, VA_B = 32'h0041_0123,
                          VA_C = 32'h0080_0456, VA_D = 32'h0C00_0789,
                          VA_E = 32'h2000_0000, VA_G = 32'h0540_2ABC,
                          VA_H = 32'h0540_6DEF, VA_K = 32'h0600_0010,
                          VA_L = 32'h0700_0020;
  localparam logic [18:0] PB_A = 19'h12345, PB_B = 19'h0ABC8, PB_C = 19'h3C000,
                          PB_D = 19'h40200, PB_E = 19'h00777, PB_G = 19'h11111,
                          PB_H = 19'h22200, PB_K = 19'h00100, PB_L = 19'h00200;

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R10 reset state
    check("R10 walk_req after reset", walk_req == 1'b0, 32'(walk_req), 32'd0);
    check("R10 fault after reset", rsp_fault == 1'b0, 32'(rsp_fault), 32'd0);
    @(negedge clk);

    // R10 first lookup walks; R5 fills entries 0..3 in order; R2 each size
    fill("R10 A first 8K", VA_A, 2'd0, PB_A);
    hit ("R1 A other offset", VA_A ^ 32'h0000_1F0F, 2'd0, PB_A);
    fill("R2 B 64K", VA_B, 2'd1, PB_B);
    for (int k = 0; k < 8; k++)
      hit("R2 B sweep", {VA_B[31:16], 3'(k), 13'h0A5A ^ 13'(k)}, 2'd1, PB_B);
    fill("R2 C 256K", VA_C, 2'd2, PB_C);
    hit ("R2 C top", VA_C | 32'h0003_E000, 2'd2, PB_C);
    fill("R2 D 4M", VA_D, 2'd3, PB_D);
    for (int k = 0; k < 16; k++)
      hit("R2 D sweep", {VA_D[31:22], 22'(k * 32'h0002_4D13)}, 2'd3, PB_D);

    // R2 neighbours just outside each page miss; R8 faults store nothing
    probe("R2 A next page", VA_A ^ 32'h0000_2000);
    probe("R2 B next page", VA_B ^ 32'h0001_0000);
    probe("R2 C next page", VA_C ^ 32'h0004_0000);
    probe("R8 D next page", VA_D ^ 32'h0040_0000);
    probe("R8 repeat walks", VA_D ^ 32'h0040_0000);
    hit  ("R8 A kept", VA_A, 2'd0, PB_A);
    hit  ("R8 B kept", VA_B, 2'd1, PB_B);
    hit  ("R8 C kept", VA_C, 2'd2, PB_C);
    hit  ("R8 D kept", VA_D, 2'd3, PB_D);

    // R6 full: E evicts entry0 (A), A refill evicts entry1 (B)
    fill("R6 E evicts", VA_E, 2'd0, PB_E);
    fill("R6 A lost", VA_A, 2'd0, PB_A);
    hit ("R6 C survives", VA_C, 2'd2, PB_C);
    hit ("R6 D survives", VA_D, 2'd3, PB_D);
    hit ("R6 E present", VA_E, 2'd0, PB_E);
    fill("R6 B lost", VA_B, 2'd1, PB_B);

    // R9 flush
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    fill("R9 C after flush", VA_C, 2'd2, PB_C);
    fill("R5 G small", VA_G, 2'd0, PB_G);
    fill("R5 H large", VA_H, 2'd3, PB_H);
    xlate("R7 G double", VA_G, 2'd0, PB_G, 1'b0, 1'b0, xpa(VA_G, 2'd0, PB_G), 1'b1);
    hit ("R7 H single", VA_H, 2'd3, PB_H);
    fill("R5 K fills last", VA_K, 2'd0, PB_K);
    // pointer reset by flush: L evicts entry0 (C), C refill evicts entry1 (G)
    fill("R9 L evicts entry0", VA_L, 2'd0, PB_L);
    fill("R9 C lost", VA_C, 2'd2, PB_C);
    hit ("R9 H survives", VA_H, 2'd3, PB_H);
    hit ("R9 K survives", VA_K, 2'd0, PB_K);
    xlate("R7 G via 4M only", VA_G, 2'd3, PB_H, 1'b0, 1'b0, xpa(VA_G, 2'd3, PB_H), 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule